// File: doc/BRIEF.md
# Vector Bit-Range Mask Generator

This block produces a 128-bit vector value in which every element carries the same contiguous run of set bits. The caller gives an element-size code, a first bit position and a last bit position, and raises a one-cycle start strobe. Positions are counted from the most significant bit of the element. The run starts at the first position and climbs, wrapping past the element's least significant bit, until it reaches the last position. Both ends are included.

The finished element pattern is copied across the whole vector. One clock after the strobe the block shows the registered vector together with a one-cycle valid pulse. If the size code is illegal, the block shows a one-cycle exception pulse instead, and the vector keeps its previous value. Writing the vector into a register file and decoding the instruction that drives the block are left to the surrounding logic.

Top module: `vbitmask_gen`

## Requirements
- R1: Size code 0, 1, 2 and 3 selects an element width of 8, 16, 32 and 64 bits. The element pattern is repeated 16, 8, 4 or 2 times, so that element k occupies vector bits [k*W+W-1 : k*W].
- R2: Only the low log2(W) bits of each position operand are used. The upper bits have no effect on the result.
- R3: Position p refers to element bit W-1-p, so position 0 is the element's most significant bit.
- R4: When first < last, positions first through last are set and every other bit of the element is clear.
- R5: When first > last, positions first through W-1 and positions 0 through last are set, and the positions between last and first are clear.
- R6: When first equals last, exactly one bit is set in each element.
- R7: A strobe with a legal size code gives valid_o high for exactly one cycle, one clock after the strobe. The new vector appears on result_o in that same cycle.
- R8: A strobe with a size code of 4 or more gives spec_exc_o high for exactly one cycle, one clock after the strobe. valid_o stays low and result_o keeps its previous value.
- R9: In a cycle with no strobe in the previous cycle, valid_o and spec_exc_o are low and result_o is unchanged.
- R10: After reset, result_o is zero and valid_o and spec_exc_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request strobe |
| size_i | input | 3 | Element-size code (0..3 legal) |
| first_pos_i | input | 8 | First bit position of the run (MSB = 0) |
| last_pos_i | input | 8 | Last bit position of the run (MSB = 0) |
| result_o | output | 128 | Replicated mask vector |
| valid_o | output | 1 | One-cycle pulse when result_o is new |
| spec_exc_o | output | 1 | One-cycle pulse when the size code was illegal |

## Verification
Two kinds of response can meet in neighbouring cycles. A legal request loads the result register, and an illegal request right after it must pulse the exception while leaving that freshly loaded vector untouched. The bench provokes this by issuing strobes on consecutive clocks, with legal and illegal size codes mixed at random and idle gaps in between. Every cycle it compares result_o, valid_o and spec_exc_o against a model that holds the last legal vector and never lets the two pulses overlap.

// File: rtl/vbm_pkg.sv
// Shared constants and helpers for the vector bit-range mask generator.
// Assumes element widths are MIN_ELEM_W shifted left by the size code.
package vbm_pkg;
    localparam int unsigned NUM_SIZES  = 4;
    localparam int unsigned MIN_ELEM_W = 8;
    localparam int unsigned SEL_W      = $clog2(NUM_SIZES);

    // Element width for a legal size code.
    function automatic int unsigned elem_width(input int unsigned code);
        return MIN_ELEM_W << code;
    endfunction
endpackage

// File: rtl/vbm_range_mask.sv
// Builds one EW-bit element with the contiguous, possibly wrapping, run
// between two positions counted from the MSB. Assumes POS_W >= log2(EW).
module vbm_range_mask #(
    parameter int unsigned EW    = 8,
    parameter int unsigned POS_W = 8
) (
    input  logic [POS_W-1:0] first_i,
    input  logic [POS_W-1:0] last_i,
    output logic [EW-1:0]    mask_o
);
    localparam int unsigned IW = $clog2(EW);

    logic [IW-1:0] lo_pos;
    logic [IW-1:0] hi_pos;
    logic          wraps;

    assign lo_pos = first_i[IW-1:0];
    assign hi_pos = last_i[IW-1:0];
    assign wraps  = lo_pos > hi_pos;

    // Decide each element bit from its MSB-relative position.
    always_comb begin
        mask_o = '0;
        for (int p = 0; p < int'(EW); p++) begin
            logic [IW-1:0] pos;
            logic          above;
            logic          below;
            pos   = IW'(p);
            above = pos >= lo_pos;
            below = pos <= hi_pos;
            mask_o[EW-1-p] = wraps ? (above || below) : (above && below);
        end
    end
endmodule

// File: rtl/vbm_splat.sv
// Copies one EW-bit element into every element slot of a VEC_W-bit vector.
// Assumes VEC_W is a whole multiple of EW.
module vbm_splat #(
    parameter int unsigned EW    = 8,
    parameter int unsigned VEC_W = 128
) (
    input  logic [EW-1:0]    elem_i,
    output logic [VEC_W-1:0] vec_o
);
    localparam int unsigned COPIES = VEC_W / EW;

    for (genvar k = 0; k < COPIES; k++) begin : g_copy
        assign vec_o[k*EW +: EW] = elem_i;
    end
endmodule

// File: rtl/vbitmask_gen.sv
// Top of the vector bit-range mask generator. One mask path per legal
// element size, a size-code select, and one output register stage.
// Assumes VEC_W is a multiple of the widest element width.
module vbitmask_gen #(
    parameter int unsigned VEC_W  = 128,
    parameter int unsigned SIZE_W = 3,
    parameter int unsigned POS_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic [POS_W-1:0]  first_pos_i,
    input  logic [POS_W-1:0]  last_pos_i,
    output logic [VEC_W-1:0]  result_o,
    output logic              valid_o,
    output logic              spec_exc_o
);
    import vbm_pkg::*;

    logic [VEC_W-1:0] cand [NUM_SIZES];
    logic [VEC_W-1:0] sel_vec;
    logic             size_ok;

    for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
        localparam int unsigned EW = elem_width(k);
        logic [EW-1:0] elem;

        vbm_range_mask #(.EW(EW), .POS_W(POS_W)) i_mask (
            .first_i (first_pos_i),
            .last_i  (last_pos_i),
            .mask_o  (elem)
        );

        vbm_splat #(.EW(EW), .VEC_W(VEC_W)) i_splat (
            .elem_i (elem),
            .vec_o  (cand[k])
        );
    end

    // Legal size codes are the ones below NUM_SIZES.
    assign size_ok = size_i < SIZE_W'(NUM_SIZES);

    // Pick the candidate vector for the requested element size.
    always_comb begin
        sel_vec = cand[size_i[SEL_W-1:0]];
    end

    // Register the result and the one-cycle response pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o   <= '0;
            valid_o    <= 1'b0;
            spec_exc_o <= 1'b0;
        end else begin
            valid_o    <= start_i && size_ok;
            spec_exc_o <= start_i && !size_ok;
            if (start_i && size_ok) begin
                result_o <= sel_vec;
            end
        end
    end
endmodule

// File: rtl/vbm_chk.sv
// Protocol checker for vbitmask_gen, attached with bind.
// Assumes reset is held for at least two clocks at start-up.
module vbm_chk #(
    parameter int unsigned VEC_W  = 128,
    parameter int unsigned SIZE_W = 3,
    parameter int unsigned POS_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [SIZE_W-1:0] size_i,
    input logic [VEC_W-1:0]  result_o,
    input logic              valid_o,
    input logic              spec_exc_o
);
    // R7
    legal_gives_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && size_i < SIZE_W'(4)) |=> (valid_o && !spec_exc_o));

    // R8
    illegal_gives_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && size_i >= SIZE_W'(4)) |=> (spec_exc_o && !valid_o));

    // R9
    idle_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> (!valid_o && !spec_exc_o));

    // R9
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(result_o));

    // R6
    nonempty_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (result_o != '0));

    // R8
    pulses_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({valid_o, spec_exc_o}) <= 1);
endmodule

bind vbitmask_gen vbm_chk #(.VEC_W(VEC_W), .SIZE_W(SIZE_W), .POS_W(POS_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .size_i     (size_i),
    .result_o   (result_o),
    .valid_o    (valid_o),
    .spec_exc_o (spec_exc_o)
);

// File: tb/test_vbitmask_gen.sv
// Self-checking bench: exhaustive walk of every size/position pair plus
// seeded random back-to-back traffic, compared against a walking model.
module test_vbitmask_gen;
    localparam int CLK_P = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [2:0]   size_i = '0;
    logic [7:0]   first_pos_i = '0;
    logic [7:0]   last_pos_i = '0;
    logic [127:0] result_o;
    logic         valid_o;
    logic         spec_exc_o;

    int checks = 0;
    int errors = 0;

    logic [127:0] exp_res = '0;
    logic         exp_val = 1'b0;
    logic         exp_exc = 1'b0;
    string        exp_tag = "R10";

    vbitmask_gen i_vbitmask_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .size_i      (size_i),
        .first_pos_i (first_pos_i),
        .last_pos_i  (last_pos_i),
        .result_o    (result_o),
        .valid_o     (valid_o),
        .spec_exc_o  (spec_exc_o)
    );

    always #(CLK_P/2) clk = ~clk;

    // Walking model: set positions from first upward, wrap, stop after last.
    function automatic logic [127:0] model_vec(int sz, int a, int b);
        logic [63:0]  m = '0;
        logic [127:0] r;
        int w = 8 << sz;
        int s = a % w;
        int e = b % w;
        for (int i = s; ; i = (i + 1) % w) begin
            m[w-1-i] = 1'b1;
            if (i == e) break;
        end
        for (int j = 0; j < 128; j++) r[j] = m[j % w];
        return r;
    endfunction

    function automatic string range_tag(int sz, int a, int b);
        int w = 8 << sz;
        if ((a % w) == (b % w)) return "R6";
        if ((a % w) > (b % w)) return "R5";
        return "R4";
    endfunction

    task automatic compare();
        checks++;
        if (result_o !== exp_res || valid_o !== exp_val || spec_exc_o !== exp_exc) begin
            errors++;
            $display("FAIL %s: res=%h val=%b exc=%b expected res=%h val=%b exc=%b",
                     exp_tag, result_o, valid_o, spec_exc_o, exp_res, exp_val, exp_exc);
        end
    endtask

    // One cycle: check the previous cycle's response, then drive new inputs.
    task automatic step(bit go, int sz, int a, int b, string tag);
        @(negedge clk);
        compare();
        start_i     = go;
        size_i      = 3'(sz);
        first_pos_i = 8'(a);
        last_pos_i  = 8'(b);
        exp_val = go && sz < 4;
        exp_exc = go && sz >= 4;
        if (go && sz < 4) exp_res = model_vec(sz, a, b);
        exp_tag = tag;
    endtask

    initial begin
        int seed = 32'h5EED_1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state
        step(0, 0, 0, 0, "R10");
        // R3: position 0 is the MSB
        step(1, 0, 0, 0, "R3");
        step(1, 3, 63, 63, "R3");
        // R2: upper operand bits ignored (low 3 bits 1 and 3 -> 0x70 pattern)
        step(1, 0, 8'hF9, 8'h0B, "R2");
        step(1, 1, 8'hF0, 8'h3F, "R2");
        // R1: full element in every size
        for (int sz = 0; sz < 4; sz++) step(1, sz, 0, (8 << sz) - 1, "R1");
        // R8: illegal size after a legal one, result must hold
        step(1, 2, 5, 9, "R7");
        step(1, 4, 1, 2, "R8");
        step(1, 7, 0, 0, "R8");
        // R9: idle cycles
        step(0, 1, 3, 3, "R9");
        step(0, 5, 3, 3, "R9");
        // Exhaustive walk of every size and position pair, random upper bits
        for (int sz = 0; sz < 4; sz++) begin
            int w = 8 << sz;
            for (int s = 0; s < w; s++) begin
                for (int e = 0; e < w; e++) begin
                    int a = s + w * $urandom_range(0, 256 / w - 1);
                    int b = e + w * $urandom_range(0, 256 / w - 1);
                    step(1, sz, a, b, range_tag(sz, a, b));
                end
            end
        end
        // Random mix of legal, illegal and idle cycles
        for (int n = 0; n < 3000; n++) begin
            int  sz = $urandom_range(0, 7);
            int  a  = $urandom_range(0, 255);
            int  b  = $urandom_range(0, 255);
            bit  go = ($urandom_range(0, 3) != 0);
            string t;
            if (!go) t = "R9";
            else if (sz >= 4) t = "R8";
            else t = range_tag(sz, a, b);
            step(go, sz, a, b, t);
        end
        step(0, 0, 0, 0, "R9");
        step(0, 0, 0, 0, "R9");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule